// File: doc/BRIEF.md
# Indexed Configuration Stream Fetcher

This block is a read-only bus master on an AXI3 read address and read data channel. It loads one configuration stream from memory into a 64-bit write-side queue. A client picks the stream by number and raises a request. The fetcher first reads that stream's entry from an index table at a fixed base address. The entry gives the stream's start offset and its length in bytes. The fetcher then issues fixed 64-byte read bursts, one after another, until it has requested the whole stream. Every data beat that comes back is pushed into the queue unchanged. The length is pushed ahead of the data, so that a word-level consumer further on can tell where the stream ends.

Burst requests do not wait for earlier bursts to return their data. A small count of outstanding bursts is the only limit. The ready output comes back as soon as the last burst of a stream has been accepted, even if that stream's data is still in flight. The next stream's table lookup can therefore start at once, and its data follows the previous stream in the queue with no gap.

Top module: `cfg_stream_fetch`

## Requirements
- R1: A fetch starts in the cycle after a clock edge at which `rdy` and `start_req` are both high. In the next cycle `rdy` is low and `ar_valid` is high. While `rdy` is low, `start_req` is ignored, even if it is held high.
- R2: The first read of a fetch is the table read. It is a single beat (`ar_len` 0, `ar_size` 3) at address `BASE + 8*sel_idx`.
- R3: In the table beat, bits 31:0 hold the stream offset from `BASE` and bits 63:32 hold the length in bytes. This beat is pushed to the queue as the word `{32'h0, length}`, ahead of the stream data.
- R4: Data bursts use `ar_len` 7, `ar_size` 3, `ar_burst` 2'b01 (incrementing) and `ar_prot` 0. The first burst is at `BASE + offset`, and each accepted burst adds 64 to the address. The last burst is the one whose next address reaches or passes `BASE + offset + length`, which makes ceil(length/64) bursts. A length of zero issues no data burst.
- R5: Data bursts are issued without waiting for returned data, with up to `MAX_OUT` bursts outstanding at once.
- R6: `rdy` rises once the last burst of a stream has been accepted, even while that stream's data is still outstanding. A table entry that follows earlier data is recognised after that data and is handled as in R3.
- R7: `r_ready` is the inverse of `q_full`. Every accepted beat is pushed exactly once and in order. Data beats are pushed unmodified, including the bytes read past the end of the stream in its last burst.
- R8: Once `ar_valid` is high, it stays high and `ar_addr` and `ar_len` stay unchanged until `ar_ready` is seen.
- R9: While reset is held, `rdy` is high, and `ar_valid` and `q_wen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_idx | input | IDX_W | Stream number to fetch |
| start_req | input | 1 | Fetch request |
| rdy | output | 1 | Request can be taken |
| ar_addr | output | AW | Read address |
| ar_len | output | 4 | Burst length minus one |
| ar_size | output | 3 | Beat size code (8 bytes) |
| ar_burst | output | 2 | Burst type (incrementing) |
| ar_prot | output | 3 | Protection attributes |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| r_data | input | 64 | Read data beat |
| r_valid | input | 1 | Read data valid |
| r_last | input | 1 | Last beat of a burst |
| r_ready | output | 1 | Read data can be taken |
| q_wdata | output | 64 | Word pushed into the queue |
| q_wen | output | 1 | Queue push strobe |
| q_full | input | 1 | Queue cannot take a word |

## Verification
The assertions take the following inputs for granted:
- `BASE` and every stream offset are multiples of 64, so each burst address is burst-aligned.
- The slave returns bursts in the order they were issued, on a single ID.
- The length of each table burst matches what was requested.

The bench keeps to these. Its memory model places stream k at offset (k+1)·64 KiB and answers from an in-order queue of accepted addresses. It stalls the address channel, the data channel and the queue with a pseudo-random pattern, but never drops `r_valid` before the beat is taken.

// File: rtl/cfg_fetch_pkg.sv
`timescale 1ns/1ps
package cfg_fetch_pkg;
  typedef enum logic [1:0] {AS_IDLE, AS_TBL, AS_WAIT, AS_BURST} addr_st_e;

  localparam int BEAT_BYTES  = 8;
  localparam int BURST_BEATS = 8;
  localparam int BURST_BYTES = BEAT_BYTES * BURST_BEATS;

  localparam logic [3:0] LEN_TABLE  = 4'd0;
  localparam logic [3:0] LEN_STREAM = 4'(BURST_BEATS - 1);
  localparam logic [2:0] SIZE_8B    = 3'd3;
  localparam logic [1:0] TYPE_INCR  = 2'b01;
  localparam logic [2:0] PROT_NONE  = 3'd0;
endpackage

// File: rtl/cfg_fetch_addr_ctl.sv
`timescale 1ns/1ps
module cfg_fetch_addr_ctl
  import cfg_fetch_pkg::*;
#(
  parameter int             AW      = 32,
  parameter int             IDX_W   = 4,
  parameter logic [AW-1:0]  BASE    = '0,
  parameter int             MAX_OUT = 4,
  parameter int             OUT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              start_req,
  input  logic              ar_ready,
  input  logic              tbl_hit,
  input  logic [31:0]       tbl_off,
  input  logic [31:0]       tbl_len,
  input  logic [OUT_W-1:0]  out_cnt,
  output logic              rdy,
  output logic              ar_valid,
  output logic [AW-1:0]     ar_addr,
  output logic              ar_is_tbl,
  output logic              tbl_hs,
  output logic              burst_hs
);
  addr_st_e      st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW:0]   stop_q, stop_d;
  logic [AW:0]   next_addr;
  logic          addr_en;

  assign next_addr = {1'b0, addr_q} + (AW+1)'(BURST_BYTES);
  assign rdy       = (st_q == AS_IDLE);
  assign ar_is_tbl = (st_q == AS_TBL);
  assign ar_valid  = (st_q == AS_TBL) ||
                     ((st_q == AS_BURST) && (out_cnt < OUT_W'(MAX_OUT)));
  assign ar_addr   = addr_q;
  assign tbl_hs    = (st_q == AS_TBL) && ar_ready;
  assign burst_hs  = (st_q == AS_BURST) && ar_valid && ar_ready;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    stop_d  = stop_q;
    addr_en = 1'b0;
    case (st_q)
      AS_IDLE: if (start_req) begin
        addr_d  = BASE + AW'({sel_idx, 3'b000});
        addr_en = 1'b1;
        st_d    = AS_TBL;
      end
      AS_TBL: if (ar_ready) st_d = AS_WAIT;
      AS_WAIT: if (tbl_hit) begin
        addr_d  = BASE + AW'(tbl_off);
        stop_d  = {1'b0, BASE} + (AW+1)'(tbl_off) + (AW+1)'(tbl_len);
        addr_en = 1'b1;
        st_d    = (tbl_len == 32'd0) ? AS_IDLE : AS_BURST;
      end
      AS_BURST: if (burst_hs) begin
        addr_d  = next_addr[AW-1:0];
        addr_en = 1'b1;
        if (next_addr >= stop_q) st_d = AS_IDLE;
      end
      default: st_d = AS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AS_IDLE;
      addr_q <= '0;
      stop_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en) addr_q <= addr_d;
      if (tbl_hit) stop_q <= stop_d;
    end
  end
endmodule

// File: rtl/cfg_fetch_data_ctl.sv
`timescale 1ns/1ps
module cfg_fetch_data_ctl #(
  parameter int OUT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       r_data,
  input  logic              r_valid,
  input  logic              r_last,
  input  logic              q_full,
  input  logic              tbl_hs,
  input  logic              burst_hs,
  output logic              r_ready,
  output logic [63:0]       q_wdata,
  output logic              q_wen,
  output logic              tbl_hit,
  output logic [31:0]       tbl_off,
  output logic [31:0]       tbl_len,
  output logic [OUT_W-1:0]  out_cnt
);
  logic             pend_q, pend_d;
  logic [OUT_W-1:0] cnt_q, cnt_d;
  logic             beat_hs, is_tbl, done_burst;

  assign r_ready    = !q_full;
  assign beat_hs    = r_valid && r_ready;
  assign is_tbl     = pend_q && (cnt_q == '0);
  assign tbl_hit    = beat_hs && is_tbl;
  assign done_burst = beat_hs && r_last && !is_tbl;
  assign tbl_off    = r_data[31:0];
  assign tbl_len    = r_data[63:32];
  assign q_wen      = beat_hs;
  assign q_wdata    = is_tbl ? {32'h0, r_data[63:32]} : r_data;
  assign out_cnt    = cnt_q;

  always_comb begin
    case ({burst_hs, done_burst})
      2'b10:   cnt_d = cnt_q + OUT_W'(1);
      2'b01:   cnt_d = cnt_q - OUT_W'(1);
      default: cnt_d = cnt_q;
    endcase
    pend_d = pend_q;
    if (tbl_hs)       pend_d = 1'b1;
    else if (tbl_hit) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/cfg_stream_fetch.sv
`timescale 1ns/1ps
module cfg_stream_fetch
  import cfg_fetch_pkg::*;
#(
  parameter int             AW      = 32,
  parameter int             IDX_W   = 4,
  parameter logic [AW-1:0]  BASE    = 32'h0010_0000,
  parameter int             MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              start_req,
  output logic              rdy,
  output logic [AW-1:0]     ar_addr,
  output logic [3:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  output logic [2:0]        ar_prot,
  output logic              ar_valid,
  input  logic              ar_ready,
  input  logic [63:0]       r_data,
  input  logic              r_valid,
  input  logic              r_last,
  output logic              r_ready,
  output logic [63:0]       q_wdata,
  output logic              q_wen,
  input  logic              q_full
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  logic             ar_is_tbl, tbl_hs, burst_hs, tbl_hit;
  logic [31:0]      tbl_off, tbl_len;
  logic [OUT_W-1:0] out_cnt;

  assign ar_len   = ar_is_tbl ? LEN_TABLE : LEN_STREAM;
  assign ar_size  = SIZE_8B;
  assign ar_burst = TYPE_INCR;
  assign ar_prot  = PROT_NONE;

  cfg_fetch_addr_ctl #(
    .AW(AW), .IDX_W(IDX_W), .BASE(BASE), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .start_req(start_req),
    .ar_ready(ar_ready), .tbl_hit(tbl_hit), .tbl_off(tbl_off),
    .tbl_len(tbl_len), .out_cnt(out_cnt), .rdy(rdy), .ar_valid(ar_valid),
    .ar_addr(ar_addr), .ar_is_tbl(ar_is_tbl), .tbl_hs(tbl_hs),
    .burst_hs(burst_hs)
  );

  cfg_fetch_data_ctl #(.OUT_W(OUT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .r_data(r_data), .r_valid(r_valid),
    .r_last(r_last), .q_full(q_full), .tbl_hs(tbl_hs), .burst_hs(burst_hs),
    .r_ready(r_ready), .q_wdata(q_wdata), .q_wen(q_wen), .tbl_hit(tbl_hit),
    .tbl_off(tbl_off), .tbl_len(tbl_len), .out_cnt(out_cnt)
  );
endmodule

// File: rtl/cfg_stream_fetch_chk.sv
`timescale 1ns/1ps
module cfg_stream_fetch_chk #(
  parameter int             AW    = 32,
  parameter int             IDX_W = 4,
  parameter logic [AW-1:0]  BASE  = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  sel_idx,
  input logic              start_req,
  input logic              rdy,
  input logic [AW-1:0]     ar_addr,
  input logic [3:0]        ar_len,
  input logic [2:0]        ar_size,
  input logic [1:0]        ar_burst,
  input logic [2:0]        ar_prot,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic              q_wen,
  input logic              q_full
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && start_req |=> !rdy && ar_valid && ar_len == 4'd0); // R1
  AST_TABLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && start_req |=> ar_addr == BASE + AW'({$past(sel_idx), 3'b000})); // R2
  AST_BURST_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_size == 3'd3 && ar_burst == 2'b01 && ar_prot == 3'd0 &&
                 (ar_len == 4'd0 || ar_len == 4'd7)); // R4
  AST_BURST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && ar_len == 4'd7 |-> ar_addr[5:0] == 6'd0); // R4
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_len)); // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !q_wen); // R7
  AST_PUSH_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    q_wen |-> r_valid && r_ready); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !ar_valid); // R6
endmodule

bind cfg_stream_fetch cfg_stream_fetch_chk #(.AW(AW), .IDX_W(IDX_W), .BASE(BASE)) u_chk (.*);

// File: tb/cfg_stream_fetch_tb.sv
`timescale 1ns/1ps
module cfg_stream_fetch_tb;
  localparam int          AW      = 32;
  localparam int          IDX_W   = 4;
  localparam int          MAX_OUT = 4;
  localparam logic [31:0] BASE    = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic [IDX_W-1:0] sel_idx;
  logic start_req;
  logic rdy, ar_valid, ar_ready, r_valid, r_last, r_ready, q_wen, q_full;
  logic [AW-1:0] ar_addr;
  logic [3:0] ar_len;
  logic [2:0] ar_size, ar_prot;
  logic [1:0] ar_burst;
  logic [63:0] r_data, q_wdata;

  always #5 clk = ~clk;

  cfg_stream_fetch #(.AW(AW), .IDX_W(IDX_W), .BASE(BASE), .MAX_OUT(MAX_OUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .start_req(start_req), .rdy(rdy),
    .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .ar_prot(ar_prot), .ar_valid(ar_valid), .ar_ready(ar_ready), .r_data(r_data),
    .r_valid(r_valid), .r_last(r_last), .r_ready(r_ready), .q_wdata(q_wdata),
    .q_wen(q_wen), .q_full(q_full));

  function automatic logic [31:0] tlen(input int k);
    case (k)
      0: return 0;    1: return 1;    2: return 8;    3: return 63;
      4: return 64;   5: return 65;   6: return 127;  7: return 128;
      8: return 129;  9: return 200;  10: return 256; 11: return 300;
      12: return 511; 13: return 512; 14: return 513; 15: return 640;
      default: return 0;
    endcase
  endfunction
  function automatic logic [31:0] toff(input int k);
    return 32'((k + 1) << 16);
  endfunction
  function automatic logic [63:0] mem(input logic [31:0] a);
    if (a < BASE + 32'h1000) begin
      int k = int'((a - BASE) >> 3);
      return {tlen(k), toff(k)};
    end
    return {a, ~a};
  endfunction

  // memory-side model: in-order burst queue
  logic [31:0] sq_addr [64];
  logic [3:0]  sq_len  [64];
  logic [5:0]  wp, rp;
  logic [3:0]  beat;
  logic        r_gate, ar_rdy_q;
  logic [15:0] lfsr;
  bit thr_ar = 0, thr_r = 0, thr_q = 0;

  assign ar_ready = ar_rdy_q;
  assign r_valid  = (wp != rp) && r_gate;
  assign r_data   = mem(sq_addr[rp] + {25'd0, beat, 3'b000});
  assign r_last   = (beat == sq_len[rp]);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; beat <= '0; r_gate <= 1'b0; ar_rdy_q <= 1'b0;
      lfsr <= 16'hACE1; q_full <= 1'b0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ar_valid && ar_ready) begin
        sq_addr[wp] <= ar_addr; sq_len[wp] <= ar_len; wp <= wp + 6'd1;
      end
      if (r_valid && r_ready) begin
        if (r_last) begin rp <= rp + 6'd1; beat <= '0; end
        else beat <= beat + 4'd1;
      end
      ar_rdy_q <= thr_ar ? lfsr[2] : 1'b1;
      if (!(r_valid && !r_ready)) r_gate <= thr_r ? (lfsr[0] & lfsr[1]) : 1'b1;
      q_full <= thr_q ? (lfsr[3] & lfsr[4]) : 1'b0;
    end
  end

  // bookkeeping of expected and observed traffic
  logic [63:0] exp_w [2048];  bit exp_sz [2048];  int exp_n = 0;
  logic [63:0] got_w [2048];  int got_n = 0;
  logic [31:0] ear_a [512];   logic [3:0] ear_l [512];  int ear_n = 0;
  logic [31:0] gar_a [512];   logic [3:0] gar_l [512];  int gar_n = 0;
  int checks = 0, errors = 0;
  int iss = 0, dne = 0, maxout = 0, rr_bad = 0, hold_bad = 0, nreq = 0;
  bit pre_seen = 0, rdy_prev = 1, pv_stall = 0;
  logic [31:0] pv_addr;

  always @(negedge clk) if (rst_n) begin
    if (pv_stall && !(ar_valid && ar_addr == pv_addr)) hold_bad++;
    pv_stall = ar_valid && !ar_ready;
    pv_addr  = ar_addr;
    if (ar_valid && ar_ready) begin
      gar_a[gar_n] = ar_addr; gar_l[gar_n] = ar_len; gar_n++;
      if (ar_len == 4'd7) iss++;
    end
    if (r_valid && r_ready && r_last && sq_len[rp] == 4'd7) dne++;
    if (iss - dne > maxout) maxout = iss - dne;
    if (q_wen) begin got_w[got_n] = q_wdata; got_n++; end
    if (r_ready == q_full) rr_bad++;
    if (rdy && !rdy_prev && iss != dne) pre_seen = 1;
    rdy_prev = rdy;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add_exp(input int k);
    int nb = int'((tlen(k) + 32'd63) >> 6);
    exp_w[exp_n] = {32'h0, tlen(k)}; exp_sz[exp_n] = 1; exp_n++;
    ear_a[ear_n] = BASE + 32'(k * 8); ear_l[ear_n] = 4'd0; ear_n++;
    for (int b = 0; b < nb; b++) begin
      logic [31:0] ba = BASE + toff(k) + 32'(b * 64);
      ear_a[ear_n] = ba; ear_l[ear_n] = 4'd7; ear_n++;
      for (int j = 0; j < 8; j++) begin
        exp_w[exp_n] = {ba + 32'(j * 8), ~(ba + 32'(j * 8))}; exp_sz[exp_n] = 0; exp_n++;
      end
    end
    nreq++;
  endtask

  task automatic do_req(input int k);
    @(posedge clk); #1;
    sel_idx = IDX_W'(k); start_req = 1'b1;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    add_exp(k);
    @(negedge clk);
    chk(!rdy && ar_valid, "R1 busy after start", {62'd0, rdy, ar_valid}, 64'd1);
    chk(ar_addr == BASE + 32'(k * 8) && ar_len == 4'd0 && ar_size == 3'd3,
        "R2 table read", {ar_addr, 25'd0, ar_size, ar_len}, {BASE + 32'(k * 8), 25'd0, 3'd3, 4'd0});
  endtask

  task automatic wait_drain();
    @(negedge clk);
    while (!(got_n == exp_n && rdy && wp == rp)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string ph);
    int bad = -1;
    int tb = 0;
    chk(got_n == exp_n, {"R7 push count ", ph}, 64'(got_n), 64'(exp_n));
    if (got_n == exp_n)
      for (int i = 0; i < exp_n; i++) if (bad < 0 && got_w[i] !== exp_w[i]) bad = i;
    if (bad >= 0) chk(0, exp_sz[bad] ? {"R3 size word ", ph} : {"R7 data word ", ph}, got_w[bad], exp_w[bad]);
    else chk(1, "R3 R7 stream", 0, 0);
    bad = -1;
    chk(gar_n == ear_n, {"R4 burst count ", ph}, 64'(gar_n), 64'(ear_n));
    if (gar_n == ear_n)
      for (int i = 0; i < ear_n; i++)
        if (bad < 0 && (gar_a[i] !== ear_a[i] || gar_l[i] !== ear_l[i])) bad = i;
    if (bad >= 0) chk(0, {"R4 burst address ", ph}, {28'd0, gar_l[bad], gar_a[bad]}, {28'd0, ear_l[bad], ear_a[bad]});
    else chk(1, "R4 bursts", 0, 0);
    for (int i = 0; i < gar_n; i++) if (gar_l[i] == 4'd0) tb++;
    chk(tb == nreq, {"R1 one table read per request ", ph}, 64'(tb), 64'(nreq));
  endtask

  initial begin
    rst_n = 1'b0; sel_idx = '0; start_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R9 reset rdy", 64'(rdy), 64'd1);
    chk(ar_valid == 1'b0, "R9 reset ar_valid", 64'(ar_valid), 64'd0);
    chk(q_wen == 1'b0, "R9 reset q_wen", 64'(q_wen), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // sequential sweep, free-running slave
    for (int k = 0; k < 16; k++) begin
      do_req(k);
      start_req = 1'b0;
      wait_drain();
    end
    compare("sequential");
    chk(maxout >= 2, "R5 bursts outstanding", 64'(maxout), 64'd2);

    // back-to-back sweep with stalls; request held while busy
    thr_ar = 1; thr_r = 1; thr_q = 1;
    for (int k = 15; k >= 0; k--) do_req(k);
    @(posedge clk); #1 start_req = 1'b0;
    wait_drain();
    compare("preload");
    chk(pre_seen, "R6 ready while data in flight", 64'(pre_seen), 64'd1);
    chk(rr_bad == 0, "R7 r_ready follows queue", 64'(rr_bad), 64'd0);
    chk(hold_bad == 0, "R8 address held under stall", 64'(hold_bad), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule